// File: doc/BRIEF.md
# Gated-Window Clock Frequency Meter

This block measures the frequency of one of several local clocks. It counts that clock's edges while a gate is open. The gate stays open for a programmable number of cycles of the reference clock `clk`. Software, or a calibration controller, drives a simple register port. It first sets an enable bit, then sets a run bit in a later write. It then polls until run reads back as zero and reads the edge count. With the reset window of 512 reference cycles and a 26 MHz reference, the measured frequency in MHz is count×26/512.

The design has two clock domains. The reference-domain controller opens and closes the gate and times the window. A second domain, clocked by the selected source, counts edges. The gate and the counter's busy flag each cross between the domains through a two-flop synchroniser. The controller is a five-state machine:

- IDLE: waits for a start request. Start goes to DRAIN.
- DRAIN: waits until the counter domain reports not busy, then goes to ARM.
- ARM: opens the gate and times the window. When the busy flag is seen, it goes to WINDOW.
- WINDOW: keeps timing. When the window count reaches its limit, it goes to CLOSE.
- CLOSE: drops the gate. When busy is seen low again, it captures the count and goes back to IDLE.

Clearing the enable bit forces IDLE from any state.

Top module: `freq_meter`

## Requirements
- R1: After reset the words read as follows:
  - word 0 (control) = 0x00000000
  - word 1 = 0x01FF0000 (window limit 511, result 0)
  - word 2 (source) = 0
  - word 3 (divisor) = 0
- R2: A start happens only for a write to word 0 with bit 0 (enable) and bit 1 (run) both 1 while enable was already 1. A write that sets enable and run together from the disabled state leaves run reading 0.
- R3: Word 0 bit 1 reads 1 from the clock edge of an accepted start until the measurement finishes, and then clears by itself.
- R4: The result is the number of counted edges of the measured clock during (L+1) reference cycles, within ±2, where L is word 1 bits [25:16].
- R5: Word 2 bits [14:8] hold a source index. An index below NSRC selects `src_clk[index]`.
- R6: Word 3 bits [31:24] hold a value D. The measured clock is pre-divided by D+1, so 0 counts every edge.
- R7: If word 2 bits [1:0] are not 00, or the source index is NSRC or above, no clock reaches the counter and run stays 1.
- R8: Writing enable = 0 aborts any measurement. Run reads 0 within two reference cycles of that write, and a following measurement gives a correct result.
- R9: The result field reads 0 from an accepted start until completion. It then holds its value, including across writes to words 2 and 3, until the next start.
- R10: Word 1 returns the window limit in bits [25:16] and the result in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the window and runs the register port |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| src_clk | input | NSRC | Candidate clocks to measure |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word read |
| rd_data | output | 32 | Read data, combinational from rd_addr |

## Verification
Two things can land on the same write: enable rising and the run request. The bench provokes this by writing 0x3 to word 0 straight after reset. It then judges the result from the port: run must read 0 and the result must stay 0, while enable reads 1. A second case checks that clearing enable during an open window wins over the window running on to completion. After that abort, the run bit and a fresh measurement's count show whether the counter domain was drained correctly.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int LOAD_W = 10;
    localparam int SEL_W  = 7;
    localparam int MODE_W = 2;
    localparam int DIV_W  = 8;
    localparam int RES_W  = 16;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_SRC  = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int B_EN  = 0;
    localparam int B_RUN = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_ARM,
        ST_WINDOW,
        ST_CLOSE
    } fm_state_e;
endpackage

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
#(
    parameter int LOAD_RST = 511
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              busy_i,
    input  logic [RES_W-1:0]  result_i,
    output logic              en_o,
    output logic              start_o,
    output logic [LOAD_W-1:0] load_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [DIV_W-1:0]  div_o
);
    logic en_q;
    logic [LOAD_W-1:0] load_q;
    logic [SEL_W-1:0]  sel_q;
    logic [MODE_W-1:0] mode_q;
    logic [DIV_W-1:0]  div_q;
    logic unused_bits;

    assign unused_bits = ^{wr_data[7:2], wr_data[15]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            load_q <= LOAD_W'(LOAD_RST);
            sel_q  <= '0;
            mode_q <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: en_q <= wr_data[B_EN];
                A_LOAD: load_q <= wr_data[16 +: LOAD_W];
                A_SRC: begin
                    sel_q  <= wr_data[8 +: SEL_W];
                    mode_q <= wr_data[0 +: MODE_W];
                end
                A_DIV: div_q <= wr_data[24 +: DIV_W];
                default: ;
            endcase
        end
    end

    // run is honoured only when enable was already set before this write
    assign start_o = wr_en && (wr_addr == A_CTRL) && wr_data[B_EN]
                     && wr_data[B_RUN] && en_q && !busy_i;

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = {30'b0, busy_i, en_q};
            A_LOAD:  rd_data = {6'b0, load_q, result_i};
            A_SRC:   rd_data = {17'b0, sel_q, 6'b0, mode_q};
            default: rd_data = {div_q, 24'b0};
        endcase
    end

    assign en_o   = en_q;
    assign load_o = load_q;
    assign sel_o  = sel_q;
    assign mode_o = mode_q;
    assign div_o  = div_q;
endmodule

// File: rtl/fm_meas.sv
module fm_meas
    import fm_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0]   src_clk_i,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              gate_i,
    output logic              busy_o,
    output logic [RES_W-1:0]  count_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic mclk;
    logic path_ok;
    logic gate_s1, gate_s2;
    logic [DIV_W-1:0] pre_q;
    logic [RES_W-1:0] cnt_q;

    assign path_ok = (mode_i == '0) && (sel_i < SEL_W'(NSRC));
    assign mclk    = path_ok ? src_clk_i[sel_i[IDX_W-1:0]] : 1'b0;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            gate_s1 <= 1'b0;
            gate_s2 <= 1'b0;
        end else begin
            gate_s1 <= gate_i;
            gate_s2 <= gate_s1;
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (gate_s1 && !gate_s2) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (gate_s2) begin
            if (pre_q == div_i) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign busy_o  = gate_s2;
    assign count_o = cnt_q;

    // R4
    count_frozen_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (!gate_s1 && !gate_s2) |=> $stable(cnt_q));
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
    import fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [LOAD_W-1:0] load_i,
    input  logic              busy_meas_i,
    input  logic [RES_W-1:0]  count_i,
    output logic              gate_o,
    output logic              busy_o,
    output logic [RES_W-1:0]  result_o
);
    fm_state_e state_q, state_d;
    logic bsy_s1, bsy_s2;
    logic [LOAD_W-1:0] win_q, lim_q;
    logic win_done;
    logic gate_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsy_s1 <= 1'b0;
            bsy_s2 <= 1'b0;
        end else begin
            bsy_s1 <= busy_meas_i;
            bsy_s2 <= bsy_s1;
        end
    end

    assign win_done = (win_q == lim_q);

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start_i)  state_d = ST_DRAIN;
                ST_DRAIN:  if (!bsy_s2)  state_d = ST_ARM;
                ST_ARM:    if (bsy_s2)   state_d = ST_WINDOW;
                ST_WINDOW: if (win_done) state_d = ST_CLOSE;
                ST_CLOSE:  if (!bsy_s2)  state_d = ST_IDLE;
                default:                 state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            win_q  <= '0;
            lim_q  <= '0;
            res_q  <= '0;
        end else begin
            gate_q <= (state_d == ST_ARM) || (state_d == ST_WINDOW);
            unique case (state_q)
                ST_IDLE: if (state_d == ST_DRAIN) begin
                    res_q <= '0;
                    lim_q <= load_i;
                end
                ST_DRAIN: win_q <= '0;
                ST_ARM, ST_WINDOW: if (gate_q && !win_done) win_q <= win_q + 1'b1;
                ST_CLOSE: if (state_d == ST_IDLE && en_i) res_q <= count_i;
                default: ;
            endcase
        end
    end

    assign gate_o   = gate_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign result_o = res_q;

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);
    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(res_q));
    // R3
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !gate_q);
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int LOAD_RST = 511
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      rd_addr,
    output logic [31:0]     rd_data
);
    logic en, start, gate, busy, meas_busy;
    logic [LOAD_W-1:0] load;
    logic [SEL_W-1:0]  sel;
    logic [MODE_W-1:0] mode;
    logic [DIV_W-1:0]  div;
    logic [RES_W-1:0]  count, result;

    fm_regs #(.LOAD_RST(LOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy_i(busy), .result_i(result), .en_o(en), .start_o(start),
        .load_o(load), .sel_o(sel), .mode_o(mode), .div_o(div)
    );

    fm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en), .start_i(start),
        .load_i(load), .busy_meas_i(meas_busy), .count_i(count),
        .gate_o(gate), .busy_o(busy), .result_o(result)
    );

    fm_meas #(.NSRC(NSRC)) u_meas (
        .src_clk_i(src_clk), .rst_n(rst_n), .sel_i(sel), .mode_i(mode),
        .div_i(div), .gate_i(gate), .busy_o(meas_busy), .count_o(count)
    );
endmodule

// File: tb/freq_meter_tb.sv
`timescale 1ns/100ps
module freq_meter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0] src_clk;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always #3.5 s0 = ~s0;
    always #5 s1 = ~s1;
    always #6.5 s2 = ~s2;
    always #20 s3 = ~s3;
    assign src_clk = {s3, s2, s1, s0};

    freq_meter u_dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {source index[1:0], divisor[7:0], window limit[9:0]}
    localparam logic [19:0] VEC [7] = '{
        {2'd0, 8'd0,   10'd511},
        {2'd1, 8'd0,   10'd511},
        {2'd2, 8'd0,   10'd255},
        {2'd3, 8'd0,   10'd99},
        {2'd1, 8'd1,   10'd511},
        {2'd0, 8'd3,   10'd1023},
        {2'd2, 8'd255, 10'd1023}
    };

    function automatic int per10(input int idx);
        case (idx)
            0: return 70;
            1: return 100;
            2: return 130;
            default: return 400;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_done(input int lim, output bit ok);
        logic [31:0] d;
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            rd(2'd0, d);
            if (!d[1]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(input int idx, input int dv, input int ld, input string req);
        logic [31:0] d;
        bit ok;
        int exp, got;
        wr(2'd2, 32'(idx) << 8);
        wr(2'd3, 32'(dv) << 24);
        wr(2'd1, 32'(ld) << 16);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h3);
        wait_done(8000, ok);
        chk(ok, {req, " R3 run self-clears"}, ok, 1);
        rd(2'd1, d);
        got = int'(d[15:0]);
        exp = (ld + 1) * 200 / (per10(idx) * (dv + 1));
        chk((got >= exp - 2) && (got <= exp + 2), {req, " R4 count"}, got, exp);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, held;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R10 reset values
        rd(2'd0, d); chk(d == 32'h0, "R1 ctrl", d, 0);
        rd(2'd1, d); chk(d == 32'h01FF0000, "R10 load word", d, 32'h01FF0000);
        rd(2'd2, d); chk(d == 32'h0, "R1 source", d, 0);
        rd(2'd3, d); chk(d == 32'h0, "R1 divisor", d, 0);

        // R2 enable and run in one write from disabled: no start
        wr(2'd0, 32'h3);
        rd(2'd0, d); chk(d == 32'h1, "R2 same-write start ignored", d, 1);
        repeat (100) @(negedge clk);
        rd(2'd1, d); chk(d[15:0] == 16'h0, "R2 no result", d[15:0], 0);

        // vector table: R4 R5 R6
        for (int i = 0; i < 7; i++)
            measure(int'(VEC[i][19:18]), int'(VEC[i][17:10]), int'(VEC[i][9:0]), "R5 R6 vec");

        // R9 result held across config writes, cleared on start
        rd(2'd1, held);
        wr(2'd2, 32'h0000_0200);
        wr(2'd3, 32'h0500_0000);
        repeat (50) @(negedge clk);
        rd(2'd1, d); chk(d[15:0] == held[15:0], "R9 hold", d[15:0], held[15:0]);
        wr(2'd0, 32'h3);
        rd(2'd0, d); chk(d[1] == 1'b1, "R3 run set after start", d[1], 1);
        rd(2'd1, d); chk(d[15:0] == 16'h0, "R9 cleared on start", d[15:0], 0);
        wait_done(8000, ok);
        chk(ok, "R3 completes", ok, 1);

        // R7 mode not 00: no clock, run stays 1; R8 abort
        wr(2'd2, 32'h0000_0101);
        wr(2'd0, 32'h3);
        repeat (3000) @(negedge clk);
        rd(2'd0, d); chk(d[1] == 1'b1, "R7 mode blocks clock", d[1], 1);
        wr(2'd0, 32'h0);
        @(negedge clk);
        rd(2'd0, d); chk(d[1] == 1'b0, "R8 abort clears run", d[1], 0);

        // R7 out-of-range source index
        wr(2'd2, 32'h0000_0900);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h3);
        repeat (3000) @(negedge clk);
        rd(2'd0, d); chk(d[1] == 1'b1, "R7 index out of range", d[1], 1);
        wr(2'd0, 32'h0);
        @(negedge clk);
        rd(2'd0, d); chk(d[1] == 1'b0, "R8 abort idle source", d[1], 0);

        // R8 abort an open window, then a correct measurement
        wr(2'd2, 32'h0000_0100);
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd511 << 16);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h3);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h0);
        @(negedge clk);
        rd(2'd0, d); chk(d[1] == 1'b0, "R8 abort mid-window", d[1], 0);
        measure(1, 0, 511, "R8 after abort");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule